// File: doc/BRIEF.md
# Cross-Clock Memory Port Bridge

This block lets a requester clocked by one clock read and write a single-port synchronous memory that belongs to a second, unrelated clock domain. The memory port is also shared with other requesters that already run on the memory clock. Each request is packed into one word holding a write flag, an address and write data. That word crosses to the memory domain through an asynchronous FIFO. Gray-coded pointers are passed through two-flop synchronizers.

On the memory side, a sequencer takes the head request when the port selector grants it. A write completes with no reply. A read waits one memory clock for the data and then pushes that word into a second asynchronous FIFO. That FIFO returns the word to the requester clock domain. Both FIFOs present their head word without a prior read strobe. The requester may have only one read in flight, so responses need no tags. The transfer delay is several clocks and depends on the clock ratio, so the requester works from the handshake flags only.

Top module: `xclk_mem_bridge`

## Requirements
- R1: A request is accepted on a req_clk edge where rq_valid and rq_ready are both 1. Every accepted request is performed exactly once on the memory port, with its own write flag, address and data, and in acceptance order.
- R2: Writes are posted. An accepted write never produces a response word, so rsp_valid stays 0 when only writes are outstanding.
- R3: A read returns the memory word at its address on rsp_data with rsp_valid at 1, before any rsp_pop. The word and rsp_valid hold until the req_clk edge where rsp_pop is 1.
- R4: After a read is accepted, rq_ready is 0 while rq_write is 0, until that read's response has been popped. Writes stay acceptable during this time.
- R5: The request FIFO holds 2^QLOG2 entries (4 by default). rq_ready is 0 while it is full.
- R6: The shared port goes to at most one requester per cycle. The bridge sequencer has priority over all local requesters, and among local requesters the lowest index wins. mem_en, mem_we, mem_addr and mem_wdata follow the granted requester.
- R7: The memory has a one-cycle read latency. The sequencer captures mem_rdata one mem_clk after it issues the read, and it issues no read while the response FIFO is full.
- R8: After reset, both FIFOs are empty: rq_ready is 1, rsp_valid is 0, and mem_en is 0 while no local requester is active. Each domain has its own active-low reset, released synchronously to its own clock.
- R9: R1 to R7 hold for any clock ratio, including a memory clock 5 times slower or 5 times faster than req_clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_clk | input | 1 | Requester-side clock |
| req_rst_n | input | 1 | Requester-side asynchronous reset, active low |
| rq_valid | input | 1 | Request present |
| rq_write | input | 1 | 1 = write, 0 = read |
| rq_addr | input | AW | Request address |
| rq_wdata | input | DW | Write data |
| rq_ready | output | 1 | Request can be accepted this cycle |
| rsp_valid | output | 1 | Read response word present |
| rsp_data | output | DW | Read response word |
| rsp_pop | input | 1 | Consume the response word |
| mem_clk | input | 1 | Memory-side clock |
| mem_rst_n | input | 1 | Memory-side asynchronous reset, active low |
| loc_req | input | NLOC | Local requester port requests |
| loc_we | input | NLOC | Local requester write flags |
| loc_addr | input | NLOC*AW | Local requester addresses, index 0 in the low bits |
| loc_wdata | input | NLOC*DW | Local requester write data, index 0 in the low bits |
| loc_gnt | output | NLOC | Local requester grants |
| loc_rdata | output | DW | Memory read data seen by local requesters |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one mem_clk after a read |

## Verification
The hardest state to reach from the ports is a full request FIFO that holds a read behind which writes are queued. In that state the read blocking and the full flag are both visible, and the ordering of the read against younger writes to the same address matters. The bench reaches this state by gating the memory clock. It then pushes a read and three writes, checks both ready conditions, and releases the clock. Bridge priority is shown by a local requester that asks for the port on every cycle, while bridge traffic still completes. Random traffic runs with the memory clock five times slower and then five times faster than req_clk.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
  typedef enum logic [0:0] {
    SQ_IDLE   = 1'b0,
    SQ_RDWAIT = 1'b1
  } sq_state_e;
endpackage

// File: rtl/xmb_rst_sync.sv
module xmb_rst_sync (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [1:0] shift_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) shift_q <= 2'b00;
    else           shift_q <= {shift_q[0], 1'b1};
  end

  assign rst_out_n = shift_q[1];
endmodule

// File: rtl/xmb_afifo.sv
module xmb_afifo #(
  parameter int W     = 8,
  parameter int ALOG2 = 2
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  output logic         full,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty
);
  localparam int DEPTH = 1 << ALOG2;
  localparam int PW    = ALOG2 + 1;

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wbin_q, wgray_q, wbin_nx, wgray_nx;
  logic [PW-1:0] rbin_q, rgray_q, rbin_nx, rgray_nx;
  logic [PW-1:0] rg_s1_q, rg_s2_q;   // read pointer in write domain
  logic [PW-1:0] wg_s1_q, wg_s2_q;   // write pointer in read domain
  logic          full_nx, empty_nx;
  logic          wr_fire, rd_fire;

  // write domain
  assign wr_fire  = push && !full;
  assign wbin_nx  = wbin_q + {{(PW-1){1'b0}}, wr_fire};
  assign wgray_nx = (wbin_nx >> 1) ^ wbin_nx;
  assign full_nx  = (wgray_nx == {~rg_s2_q[PW-1:PW-2], rg_s2_q[PW-3:0]});

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full    <= 1'b0;
      rg_s1_q <= '0;
      rg_s2_q <= '0;
    end else begin
      wbin_q  <= wbin_nx;
      wgray_q <= wgray_nx;
      full    <= full_nx;
      rg_s1_q <= rgray_q;
      rg_s2_q <= rg_s1_q;
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_fire) store[wbin_q[ALOG2-1:0]] <= wdata;
  end

  // read domain
  assign rd_fire  = pop && !empty;
  assign rbin_nx  = rbin_q + {{(PW-1){1'b0}}, rd_fire};
  assign rgray_nx = (rbin_nx >> 1) ^ rbin_nx;
  assign empty_nx = (rgray_nx == wg_s2_q);

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      empty   <= 1'b1;
      wg_s1_q <= '0;
      wg_s2_q <= '0;
    end else begin
      rbin_q  <= rbin_nx;
      rgray_q <= rgray_nx;
      empty   <= empty_nx;
      wg_s1_q <= wgray_q;
      wg_s2_q <= wg_s1_q;
    end
  end

  // head word shown without a read strobe
  assign rdata = store[rbin_q[ALOG2-1:0]];

  // R5
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    push |-> !full);

  // R3
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    pop |-> !empty);
endmodule

// File: rtl/xmb_sequencer.sv
module xmb_sequencer
  import xmb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_we,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          cmd_pop,
  output logic          port_req,
  output logic          port_we,
  output logic [AW-1:0] port_addr,
  output logic [DW-1:0] port_wdata,
  input  logic          port_gnt,
  input  logic [DW-1:0] port_rdata,
  input  logic          rsp_full,
  output logic          rsp_push,
  output logic [DW-1:0] rsp_word
);
  sq_state_e state_q, state_nx;

  assign port_req   = (state_q == SQ_IDLE) && cmd_valid && (cmd_we || !rsp_full);
  assign port_we    = cmd_we;
  assign port_addr  = cmd_addr;
  assign port_wdata = cmd_wdata;
  assign cmd_pop    = port_req && port_gnt;
  assign rsp_push   = (state_q == SQ_RDWAIT);
  assign rsp_word   = port_rdata;

  always_comb begin
    state_nx = state_q;
    case (state_q)
      SQ_IDLE:   if (cmd_pop && !cmd_we) state_nx = SQ_RDWAIT;
      SQ_RDWAIT: state_nx = SQ_IDLE;
      default:   state_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_nx;
  end

  // R7
  rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_req && port_gnt && !port_we) |=> rsp_push);

  // R2
  wr_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_req && port_gnt && port_we) |=> !rsp_push);

  // R1
  pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pop |-> cmd_valid);
endmodule

// File: rtl/xmb_port_sel.sv
module xmb_port_sel #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int N  = 3
) (
  input  logic [N-1:0]    req,
  input  logic [N-1:0]    we,
  input  logic [N*AW-1:0] addr,
  input  logic [N*DW-1:0] wdata,
  output logic [N-1:0]    gnt,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata
);
  // lowest index wins; index 0 is the bridge
  assign gnt    = req & (~req + {{(N-1){1'b0}}, 1'b1});
  assign mem_en = |req;

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) begin
        mem_we    = we[i];
        mem_addr  = addr[i*AW +: AW];
        mem_wdata = wdata[i*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/xclk_mem_bridge.sv
module xclk_mem_bridge #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int NLOC  = 2,
  parameter int QLOG2 = 2,
  parameter int RLOG2 = 2
) (
  input  logic              req_clk,
  input  logic              req_rst_n,
  input  logic              rq_valid,
  input  logic              rq_write,
  input  logic [AW-1:0]     rq_addr,
  input  logic [DW-1:0]     rq_wdata,
  output logic              rq_ready,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data,
  input  logic              rsp_pop,
  input  logic              mem_clk,
  input  logic              mem_rst_n,
  input  logic [NLOC-1:0]   loc_req,
  input  logic [NLOC-1:0]   loc_we,
  input  logic [NLOC*AW-1:0] loc_addr,
  input  logic [NLOC*DW-1:0] loc_wdata,
  output logic [NLOC-1:0]   loc_gnt,
  output logic [DW-1:0]     loc_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata
);
  localparam int CW = 1 + AW + DW;
  localparam int NP = NLOC + 1;

  logic rq_rst_s_n, mm_rst_s_n;

  xmb_rst_sync u_rq_rst (.clk(req_clk), .rst_in_n(req_rst_n), .rst_out_n(rq_rst_s_n));
  xmb_rst_sync u_mm_rst (.clk(mem_clk), .rst_in_n(mem_rst_n), .rst_out_n(mm_rst_s_n));

  // requester domain
  logic          cq_full, accept, rd_pend_q, rd_pend_nx, rsp_empty, rsp_take;
  logic [CW-1:0] cq_in;

  assign rq_ready  = !cq_full && (rq_write || !rd_pend_q);
  assign accept    = rq_valid && rq_ready;
  assign cq_in     = {rq_write, rq_addr, rq_wdata};
  assign rsp_valid = !rsp_empty;
  assign rsp_take  = rsp_pop && rsp_valid;

  always_comb begin
    rd_pend_nx = rd_pend_q;
    if (accept && !rq_write) rd_pend_nx = 1'b1;
    else if (rsp_take)       rd_pend_nx = 1'b0;
  end

  always_ff @(posedge req_clk or negedge rq_rst_s_n) begin
    if (!rq_rst_s_n) rd_pend_q <= 1'b0;
    else             rd_pend_q <= rd_pend_nx;
  end

  // memory domain
  logic          cq_empty, cq_pop, rsp_full, rsp_push;
  logic [CW-1:0] cq_out;
  logic [DW-1:0] rsp_word;
  logic          seq_req, seq_we;
  logic [AW-1:0] seq_addr;
  logic [DW-1:0] seq_wdata;
  logic [NP-1:0] sel_gnt;

  xmb_afifo #(.W(CW), .ALOG2(QLOG2)) u_cmd_q (
    .wclk(req_clk), .wrst_n(rq_rst_s_n), .push(accept), .wdata(cq_in), .full(cq_full),
    .rclk(mem_clk), .rrst_n(mm_rst_s_n), .pop(cq_pop), .rdata(cq_out), .empty(cq_empty)
  );

  xmb_afifo #(.W(DW), .ALOG2(RLOG2)) u_rsp_q (
    .wclk(mem_clk), .wrst_n(mm_rst_s_n), .push(rsp_push), .wdata(rsp_word), .full(rsp_full),
    .rclk(req_clk), .rrst_n(rq_rst_s_n), .pop(rsp_take), .rdata(rsp_data), .empty(rsp_empty)
  );

  xmb_sequencer #(.AW(AW), .DW(DW)) u_seq (
    .clk(mem_clk), .rst_n(mm_rst_s_n),
    .cmd_valid(!cq_empty), .cmd_we(cq_out[CW-1]),
    .cmd_addr(cq_out[DW +: AW]), .cmd_wdata(cq_out[DW-1:0]),
    .cmd_pop(cq_pop),
    .port_req(seq_req), .port_we(seq_we), .port_addr(seq_addr), .port_wdata(seq_wdata),
    .port_gnt(sel_gnt[0]), .port_rdata(mem_rdata),
    .rsp_full(rsp_full), .rsp_push(rsp_push), .rsp_word(rsp_word)
  );

  xmb_port_sel #(.AW(AW), .DW(DW), .N(NP)) u_sel (
    .req({loc_req, seq_req}), .we({loc_we, seq_we}),
    .addr({loc_addr, seq_addr}), .wdata({loc_wdata, seq_wdata}),
    .gnt(sel_gnt), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  assign loc_gnt   = sel_gnt[NP-1:1];
  assign loc_rdata = mem_rdata;

  // R6
  bridge_first_chk: assert property (@(posedge mem_clk) disable iff (!mm_rst_s_n)
    seq_req |-> (loc_gnt == '0));

  // R4
  rsp_pending_chk: assert property (@(posedge req_clk) disable iff (!rq_rst_s_n)
    rsp_valid |-> rd_pend_q);

  // R3
  rsp_hold_chk: assert property (@(posedge req_clk) disable iff (!rq_rst_s_n)
    (rsp_valid && !rsp_pop) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: tb/xclk_mem_bridge_tb.sv
module xclk_mem_bridge_tb;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NLOC = 2;
  localparam int HALF = 1 << (AW - 1);

  logic req_clk = 1'b0, mem_clk = 1'b0;
  logic req_rst_n, mem_rst_n;
  logic rq_valid, rq_write, rq_ready, rsp_valid, rsp_pop;
  logic [AW-1:0] rq_addr;
  logic [DW-1:0] rq_wdata, rsp_data;
  logic [NLOC-1:0] loc_req, loc_we, loc_gnt;
  logic [NLOC*AW-1:0] loc_addr;
  logic [NLOC*DW-1:0] loc_wdata;
  logic [DW-1:0] loc_rdata, mem_wdata, mem_rdata;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int mem_half = 50;
  bit mem_run = 1'b1, loc_on = 1'b0;
  logic [DW-1:0] exp_mem [HALF];
  logic [DW-1:0] exp_rd;
  logic [DW-1:0] ram [1 << AW];

  xclk_mem_bridge #(.AW(AW), .DW(DW), .NLOC(NLOC)) u_dut (.*);

  always #10 req_clk = ~req_clk;
  always begin
    #(mem_half);
    if (mem_run) mem_clk = ~mem_clk;
  end

  function automatic logic [DW-1:0] seed_val(int a);
    return DW'(a * 16'h0101) ^ 16'h5A5A;
  endfunction

  initial for (int i = 0; i < (1 << AW); i++) ram[i] <= seed_val(i);
  initial for (int i = 0; i < HALF; i++) exp_mem[i] = seed_val(i);

  // memory model: one-cycle read latency
  always @(posedge mem_clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      mem_rdata <= ram[mem_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge req_clk) begin
    cyc++;
    if (cyc == 150000) begin
      chk(1'b0, "watchdog", '0, '1);
      finish_run();
    end
  end

  // local requesters: idx1 reads every cycle, idx0 writes now and then, upper half only
  always @(negedge mem_clk) begin
    if (loc_on) begin
      loc_req[1] <= 1'b1;
      loc_we[1]  <= 1'b0;
      loc_addr[AW +: AW] <= {1'b1, 7'($urandom)};
      loc_req[0] <= 1'($urandom);
      loc_we[0]  <= 1'b1;
      loc_addr[0 +: AW] <= {1'b1, 7'($urandom)};
      loc_wdata <= {16'h0, 16'($urandom)};
    end
  end

  // R6: port grant order and port contents seen at the memory pins
  always @(negedge mem_clk) begin
    #1;
    if (loc_on && loc_gnt != '0) begin
      chk(!(loc_gnt[1] && loc_req[0]) && $onehot(loc_gnt), "R6 grant order",
          DW'(loc_gnt), DW'(loc_req));
      if (loc_gnt[0]) chk(mem_addr == loc_addr[0 +: AW] && mem_we, "R6 port follows grant",
          DW'(mem_addr), DW'(loc_addr[0 +: AW]));
      if (loc_gnt[1]) chk(mem_addr == loc_addr[AW +: AW] && !mem_we, "R6 port follows grant",
          DW'(mem_addr), DW'(loc_addr[AW +: AW]));
    end
  end

  task automatic send(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge req_clk);
    rq_valid = 1'b1; rq_write = we; rq_addr = a; rq_wdata = d;
    #1;
    while (!rq_ready) begin @(negedge req_clk); #1; end
    @(posedge req_clk); #1;
    if (we) exp_mem[a[AW-2:0]] = d;
    else    exp_rd = exp_mem[a[AW-2:0]];
    rq_valid = 1'b0;
  endtask

  task automatic take_rsp(input string req);
    @(negedge req_clk);
    while (!rsp_valid) @(negedge req_clk);
    chk(rsp_data == exp_rd, req, rsp_data, exp_rd);
    rsp_pop = 1'b1;
    @(posedge req_clk); #1;
    rsp_pop = 1'b0;
  endtask

  task automatic rand_ops(input int n);
    for (int k = 0; k < n; k++) begin
      logic [AW-1:0] a;
      a = {1'b0, 7'($urandom % 16)};
      if ($urandom % 2) send(1'b1, a, 16'($urandom));
      else begin
        send(1'b0, a, '0);
        rq_write = 1'b0; #1;
        chk(rq_ready == 1'b0, "R4 read blocked", DW'(rq_ready), 16'd0);
        take_rsp("R1 R9 random read data");
      end
    end
  endtask

  initial begin
    void'($urandom(32'hC0FFEE));
    req_rst_n = 1'b0; mem_rst_n = 1'b0;
    rq_valid = 1'b0; rq_write = 1'b0; rq_addr = '0; rq_wdata = '0; rsp_pop = 1'b0;
    loc_req = '0; loc_we = '0; loc_addr = '0; loc_wdata = '0;
    #400;
    req_rst_n = 1'b1; mem_rst_n = 1'b1;
    repeat (20) @(negedge req_clk);
    #1;
    chk(rq_ready == 1'b1, "R8 ready after reset", DW'(rq_ready), 16'd1);
    chk(rsp_valid == 1'b0, "R8 no response after reset", DW'(rsp_valid), 16'd0);
    chk(mem_en == 1'b0, "R8 port idle after reset", DW'(mem_en), 16'd0);

    // memory clock 5x slower
    loc_on = 1'b1;
    send(1'b1, 8'd3, 16'hBEEF);
    send(1'b0, 8'd3, '0);
    take_rsp("R3 read after write");
    send(1'b0, 8'd9, '0);
    take_rsp("R3 untouched word");
    rand_ops(40);

    // R2: only writes outstanding, no response ever
    for (int k = 0; k < 6; k++) send(1'b1, 8'(k + 20), 16'(k * 7 + 1));
    repeat (300) @(negedge req_clk);
    chk(rsp_valid == 1'b0, "R2 posted writes", DW'(rsp_valid), 16'd0);

    // R4/R5: memory clock held, read then writes fill the FIFO
    mem_run = 1'b0;
    send(1'b0, 8'd21, '0);
    rq_write = 1'b0; #1;
    chk(rq_ready == 1'b0, "R4 second read blocked", DW'(rq_ready), 16'd0);
    rq_write = 1'b1; #1;
    chk(rq_ready == 1'b1, "R4 write still accepted", DW'(rq_ready), 16'd1);
    begin
      logic [DW-1:0] held;
      held = exp_rd;
      send(1'b1, 8'd21, 16'h1111);
      send(1'b1, 8'd22, 16'h2222);
      send(1'b1, 8'd23, 16'h3333);
      rq_write = 1'b1; #1;
      chk(rq_ready == 1'b0, "R5 full request FIFO", DW'(rq_ready), 16'd0);
      mem_run = 1'b1;
      exp_rd = held;
      take_rsp("R1 read ordered before younger write");
    end
    send(1'b0, 8'd21, '0);
    take_rsp("R1 younger write landed");

    // memory clock 5x faster
    mem_half = 2;
    rand_ops(60);
    send(1'b0, 8'd23, '0);
    take_rsp("R9 fast clock readback");

    finish_run();
  end
endmodule